// File: doc/BRIEF.md
# PPS-Synchronised Timekeeper

This block keeps wall-clock time as a pair of 32-bit counts: whole seconds and a sub-second tick count that advances once per master clock cycle. The tick count returns to zero when it reaches a programmable ticks-per-second value, and the seconds count steps by one at that moment. Software programs the block through a plain write strobe with an address. It reads the time back as two 32-bit words that always belong to the same instant.

A new time is set in three steps. Software first stages the tick value and a load mode, then writes the seconds value, and that write commits all three together. In immediate mode the committed time loads on the next cycle. In deferred mode the request stays armed until the next selected pulse-per-second event. That event is the chosen edge, rising or falling, of one of two pulse inputs, each synchronised to the master clock. The block has no data stream, so both the write port and the read port are plain control pins with no handshake and no back-pressure. Every write strobe is accepted in the cycle it is presented.

Top module: `tk_timekeeper`

## Requirements
- R1: After reset the seconds count is 0 and the tick count starts from 0, counting at the reset ticks-per-second value `RATE_RST`.
- R2: The tick count increments once per cycle. When it equals rate-1 it becomes 0 and seconds increments by 1; otherwise seconds holds.
- R3: Writes to the staged-ticks address (1) or the mode address (2) do not change the running time.
- R4: Writing the seconds address (3) while the staged mode bit 0 is 1 loads the written seconds and the staged ticks; the loaded ticks value is visible one cycle after the write edge and counting continues from there.
- R5: Writing the seconds address while mode bit 0 is 0 arms a deferred load. The time keeps running unchanged until a selected PPS event, and the load takes effect three clock edges after the pulse input changes (two synchroniser stages plus the load register).
- R6: Configuration bit 0 at address 4 selects the PPS source (0 = `pps_ext`, 1 = `pps_peer`); events on the other input are ignored.
- R7: Configuration bit 1 at address 4 selects the event edge (0 = rising, 1 = falling); the opposite edge is ignored.
- R8: A new commit replaces a pending deferred request; an immediate commit cancels it.
- R9: When `rd_en` is high with `rd_addr` 0, `rd_data` shows the current seconds and the tick count of that same cycle is captured; `rd_addr` 1 returns that captured ticks value, so the pair is coherent across a rollover.
- R10: Address 0 sets the ticks-per-second value used for the rollover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 rate, 1 staged ticks, 2 mode, 3 seconds/commit, 4 PPS config |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; with address 0 captures the ticks shadow |
| rd_addr | input | 3 | Read address: 0 seconds, 1 ticks shadow |
| rd_data | output | 32 | Read data (combinational) |
| pps_ext | input | 1 | Pulse-per-second from an external connector (asynchronous) |
| pps_peer | input | 1 | Pulse-per-second from a neighbouring unit (asynchronous) |

## Verification
On every cycle, the assertions check the rollover arithmetic, the loading of committed values, the one-cycle width of the PPS event pulse, the immediate-mode load that follows a commit, the disarming of a deferred request, and the capture of the ticks shadow. Other behaviours only show up in the bench's scenarios. These are that staged writes leave the time untouched, that edges on the unselected source or of the wrong polarity are ignored, that a later commit replaces an earlier one, and that the exact latency from a pulse input to the loaded time is as stated. The bench covers them by comparing every readback against a time computed arithmetically from the last load cycle.

// File: rtl/tk_pkg.sv
package tk_pkg;
  // Write addresses; the seconds address is the commit strobe.
  typedef enum logic [2:0] {
    WA_RATE   = 3'd0,
    WA_TICKS  = 3'd1,
    WA_MODE   = 3'd2,
    WA_SECS   = 3'd3,
    WA_PPSCFG = 3'd4
  } tk_waddr_e;

  // Read addresses.
  localparam logic [2:0] RA_SECS  = 3'd0;
  localparam logic [2:0] RA_TICKS = 3'd1;

  // Bit positions in the mode and PPS configuration words.
  localparam int unsigned MODE_NOW_BIT = 0;
  localparam int unsigned CFG_SRC_BIT  = 0;
  localparam int unsigned CFG_POL_BIT  = 1;

  localparam int unsigned PPS_NSRC = 2;
endpackage

// File: rtl/tk_pps_detect.sv
module tk_pps_detect #(
  parameter int unsigned NSRC   = tk_pkg::PPS_NSRC,
  parameter int unsigned STAGES = 2,
  localparam int unsigned SW    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pps_in,
  input  logic [SW-1:0]   src_i,
  input  logic            pol_i,    // 0 rising, 1 falling
  output logic            pulse_o
);
  logic [NSRC-1:0] synced;

  // One synchroniser chain per source.
  for (genvar s = 0; s < NSRC; s++) begin : g_sync
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], pps_in[s]};
    end
    assign synced[s] = chain_q[STAGES-1];
  end

  logic cur, prev_q;
  assign cur = synced[src_i];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign pulse_o = pol_i ? (prev_q & ~cur) : (cur & ~prev_q);

  // Two same-direction edges cannot follow each other unless config moved.
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> (!pulse_o || ($past(pol_i) != pol_i) || ($past(src_i) != src_i))); // R7
endmodule

// File: rtl/tk_regs.sv
module tk_regs
  import tk_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 3,
  parameter logic [W-1:0] RATE_RST = W'(100),
  localparam int unsigned SW = (PPS_NSRC > 1) ? $clog2(PPS_NSRC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          pps_pulse_i,
  output logic [W-1:0]  rate_o,
  output logic [SW-1:0] src_o,
  output logic          pol_o,
  output logic          load_o,
  output logic [W-1:0]  ld_secs_o,
  output logic [W-1:0]  ld_ticks_o
);
  logic [W-1:0]  rate_q, stg_ticks_q, cm_secs_q, cm_ticks_q;
  logic          stg_now_q, now_q, armed_q, pol_q;
  logic [SW-1:0] src_q;
  logic          commit;

  assign commit = wr_en && (tk_waddr_e'(wr_addr) == WA_SECS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q      <= RATE_RST;
      stg_ticks_q <= '0;
      stg_now_q   <= 1'b1;
      cm_secs_q   <= '0;
      cm_ticks_q  <= '0;
      now_q       <= 1'b0;
      armed_q     <= 1'b0;
      src_q       <= '0;
      pol_q       <= 1'b0;
    end else begin
      now_q <= 1'b0;
      if (armed_q && pps_pulse_i) armed_q <= 1'b0;
      if (wr_en) begin
        case (tk_waddr_e'(wr_addr))
          WA_RATE:   rate_q      <= wr_data;
          WA_TICKS:  stg_ticks_q <= wr_data;
          WA_MODE:   stg_now_q   <= wr_data[MODE_NOW_BIT];
          WA_PPSCFG: begin
            src_q <= SW'(wr_data[CFG_SRC_BIT]);
            pol_q <= wr_data[CFG_POL_BIT];
          end
          WA_SECS: begin
            cm_secs_q  <= wr_data;
            cm_ticks_q <= stg_ticks_q;
            if (stg_now_q) begin
              now_q   <= 1'b1;
              armed_q <= 1'b0;
            end else begin
              armed_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rate_o     = rate_q;
  assign src_o      = src_q;
  assign pol_o      = pol_q;
  assign ld_secs_o  = cm_secs_q;
  assign ld_ticks_o = cm_ticks_q;
  assign load_o     = now_q | (armed_q & pps_pulse_i);

  AST_NOW_LOADS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && stg_now_q) |=> load_o); // R4
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && pps_pulse_i && !commit) |=> !armed_q); // R5
  AST_NO_SPONTANEOUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !commit) |=> (load_o == 1'b0)); // R3
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rate_i,
  input  logic         load_i,
  input  logic [W-1:0] ld_secs_i,
  input  logic [W-1:0] ld_ticks_i,
  output logic [W-1:0] secs_o,
  output logic [W-1:0] ticks_o
);
  logic [W-1:0] secs_q, ticks_q;
  logic         wrap;

  assign wrap = (rate_i <= W'(1)) || (ticks_q >= rate_i - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secs_q  <= '0;
      ticks_q <= '0;
    end else if (load_i) begin
      secs_q  <= ld_secs_i;
      ticks_q <= ld_ticks_i;
    end else if (wrap) begin
      secs_q  <= secs_q + W'(1);
      ticks_q <= '0;
    end else begin
      ticks_q <= ticks_q + W'(1);
    end
  end

  assign secs_o  = secs_q;
  assign ticks_o = ticks_q;

  AST_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && rate_i > W'(1) && ticks_q == rate_i - W'(1))
      |=> (ticks_q == '0 && secs_q == $past(secs_q) + W'(1))); // R2
  AST_SECS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && rate_i > W'(1) && ticks_q < rate_i - W'(1))
      |=> (secs_q == $past(secs_q) && ticks_q == $past(ticks_q) + W'(1))); // R2
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (secs_q == $past(ld_secs_i) && ticks_q == $past(ld_ticks_i))); // R4
endmodule

// File: rtl/tk_timekeeper.sv
module tk_timekeeper
  import tk_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 3,
  parameter logic [W-1:0] RATE_RST = W'(100_000_000),
  localparam int unsigned SW = (PPS_NSRC > 1) ? $clog2(PPS_NSRC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          pps_ext,
  input  logic          pps_peer
);
  logic [W-1:0]  rate, ld_secs, ld_ticks, cur_secs, cur_ticks;
  logic [SW-1:0] src;
  logic          pol, load, pps_pulse;

  tk_pps_detect #(.NSRC(PPS_NSRC), .STAGES(2)) i_pps (
    .clk     (clk),
    .rst_n   (rst_n),
    .pps_in  ({pps_peer, pps_ext}),
    .src_i   (src),
    .pol_i   (pol),
    .pulse_o (pps_pulse)
  );

  tk_regs #(.W(W), .AW(AW), .RATE_RST(RATE_RST)) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .pps_pulse_i (pps_pulse),
    .rate_o      (rate),
    .src_o       (src),
    .pol_o       (pol),
    .load_o      (load),
    .ld_secs_o   (ld_secs),
    .ld_ticks_o  (ld_ticks)
  );

  tk_counter #(.W(W)) i_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_i     (rate),
    .load_i     (load),
    .ld_secs_i  (ld_secs),
    .ld_ticks_i (ld_ticks),
    .secs_o     (cur_secs),
    .ticks_o    (cur_ticks)
  );

  // Ticks shadow: captured in the same cycle the seconds word is read.
  logic [W-1:0] shadow_q;
  logic         snap;
  assign snap = rd_en && (rd_addr == RA_SECS);

  always_ff @(posedge clk) begin
    if (!rst_n)    shadow_q <= '0;
    else if (snap) shadow_q <= cur_ticks;
  end

  always_comb begin
    case (rd_addr)
      RA_SECS:  rd_data = cur_secs;
      RA_TICKS: rd_data = shadow_q;
      default:  rd_data = '0;
    endcase
  end

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (shadow_q == $past(cur_ticks))); // R9
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(shadow_q)); // R9
endmodule

// File: tb/test_tk_timekeeper.sv
`timescale 1ns/1ps
module test_tk_timekeeper;
  localparam int RST_RATE = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pps_ext = 1'b0;
  logic        pps_peer = 1'b0;

  always #2 clk = ~clk;

  tk_timekeeper #(.RATE_RST(32'(RST_RATE))) i_tk_timekeeper (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pps_ext(pps_ext), .pps_peer(pps_peer)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  // Reference: time rT/rS loaded at posedge count rL, rate rR.
  int rS, rT, rL, rR;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 32'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_time(output int s, output int t, output int c);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'd0;
    #1 s = int'(rd_data); c = cyc;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0; rd_addr = 3'd1;
    #1 t = int'(rd_data);
  endtask

  task automatic exp_check(input string req);
    int s, t, c, tot;
    rd_time(s, t, c);
    tot = rT + (c - rL);
    chk({req, " secs"}, s, rS + tot / rR);
    chk({req, " ticks"}, t, tot % rR);
  endtask

  task automatic load_now(input int secs, input int ticks, input int rate);
    wr(3'd0, rate);
    wr(3'd1, ticks);
    wr(3'd2, 1);
    wr(3'd3, secs);
    rS = secs; rT = ticks; rR = rate; rL = cyc + 1;
  endtask

  task automatic stage_pps(input int secs, input int ticks);
    wr(3'd1, ticks);
    wr(3'd2, 0);
    wr(3'd3, secs);
  endtask

  task automatic set_pps(input bit which, input bit val, output int c0);
    @(negedge clk);
    if (which) pps_peer = val; else pps_ext = val;
    c0 = cyc;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rS = 0; rT = 0; rR = RST_RATE; rL = cyc;
    // R1: reset state and default rate
    exp_check("R1");
    repeat (3) @(negedge clk);
    exp_check("R1");

    // R4 immediate load, R2 rollover sweep, R9 coherence
    load_now(7, 3, 10);
    exp_check("R4");
    for (int i = 0; i < 16; i++) begin
      repeat (i % 3) @(negedge clk);
      exp_check("R2_R9");
    end
    // R3: staging writes leave the running time alone
    wr(3'd1, 9);
    wr(3'd2, 1);
    exp_check("R3");

    // R10: different rate
    load_now(1000, 0, 4);
    for (int i = 0; i < 10; i++) exp_check("R10");
    load_now(20, 6, 7);
    for (int i = 0; i < 8; i++) begin
      repeat (i % 2) @(negedge clk);
      exp_check("R9");
    end

    // R5: deferred load on external rising edge
    wr(3'd4, 0);
    stage_pps(100, 2);
    repeat (5) @(negedge clk);
    exp_check("R5 pending");
    set_pps(1'b0, 1'b1, c0);
    rS = 100; rT = 2; rL = c0 + 3;
    repeat (4) @(negedge clk);
    exp_check("R5");
    set_pps(1'b0, 1'b0, c0);
    repeat (4) @(negedge clk);
    exp_check("R5 once");

    // R6: source select, external ignored when peer selected
    wr(3'd4, 1);
    stage_pps(200, 1);
    set_pps(1'b0, 1'b1, c0);
    repeat (6) @(negedge clk);
    exp_check("R6 ignored");
    set_pps(1'b0, 1'b0, c0);
    repeat (4) @(negedge clk);
    set_pps(1'b1, 1'b1, c0);
    rS = 200; rT = 1; rL = c0 + 3;
    repeat (4) @(negedge clk);
    exp_check("R6");
    set_pps(1'b1, 1'b0, c0);
    repeat (4) @(negedge clk);

    // R7: falling edge selected, rising ignored
    wr(3'd4, 2);
    stage_pps(300, 4);
    set_pps(1'b0, 1'b1, c0);
    repeat (6) @(negedge clk);
    exp_check("R7 rising ignored");
    set_pps(1'b0, 1'b0, c0);
    rS = 300; rT = 4; rL = c0 + 3;
    repeat (4) @(negedge clk);
    exp_check("R7");
    wr(3'd4, 0);

    // R8: later deferred commit replaces earlier one
    stage_pps(400, 5);
    stage_pps(500, 6);
    set_pps(1'b0, 1'b1, c0);
    rS = 500; rT = 6; rL = c0 + 3;
    repeat (4) @(negedge clk);
    exp_check("R8 replace");
    set_pps(1'b0, 1'b0, c0);
    repeat (4) @(negedge clk);
    // R8: immediate commit cancels pending deferred request
    stage_pps(600, 2);
    wr(3'd1, 0);
    wr(3'd2, 1);
    wr(3'd3, 700);
    rS = 700; rT = 0; rL = cyc + 1;
    set_pps(1'b0, 1'b1, c0);
    repeat (6) @(negedge clk);
    exp_check("R8 cancel");
    set_pps(1'b0, 1'b0, c0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule